// File: doc/BRIEF.md
# Serial EEPROM Station-Address Loader

The loader is a bit-banged master for a 4-wire Microwire serial EEPROM. When `start` is pulsed, it reads the whole 32-byte image one 16-bit word at a time. Each word takes its own chip-select session: an idle period, a dummy clock, the start bit, the read opcode, a 6-bit word address, one discarded status slot and sixteen data clocks. Every pin level is held for a programmable number of clock cycles, so the same logic can run slow parts from a fast system clock.

When the last word has arrived, the block XORs the bytes from the key offset up to the byte just before the checksum offset. It compares the result with the stored checksum byte. On a match it presents the 6-byte station address taken from the address offset. On a mismatch it raises an error flag and holds the address at zero. A one-cycle `done` pulse marks the end of the read.

Top module: `mw_rom_loader`

## Requirements
- R1: During and after reset, `ser_cs`, `ser_clk`, `ser_di`, `busy`, `done`, `addr_valid`, `sum_err` and `station_addr` are all zero.
- R2: While `busy` is low, all three EEPROM pins are low. Each word transaction starts with all pins low for one hold period, and then `ser_cs` rises.
- R3: The first four `ser_clk` pulses of every transaction carry `ser_di` values 0, 1, 1, 0 in that order: a dummy clock, the start bit and the read opcode 10.
- R4: Pulses 5 to 10 carry the word address MSB first, and the address is stable while `ser_clk` is high. Words 0 to 15 are read in increasing order, one transaction each.
- R5: After the address, `ser_clk` stays low for one hold period (the discarded status slot). Exactly 16 more pulses follow, so a transaction has 26 pulses in total. `ser_do` is sampled at the end of the low period that follows each of these pulses.
- R6: Every pin level lasts a whole multiple of `DELAY_CYC` clock cycles. Pins change only at a step boundary.
- R7: The first 8 data bits of word n (MSB first) form byte 2n, and the next 8 form byte 2n+1. Byte `MAC_OFS` appears in `station_addr[47:40]`, and byte `MAC_OFS+5` in `[7:0]`.
- R8: If the XOR of bytes `KEY_OFS`..`SUM_OFS-1` equals byte `SUM_OFS`, then `addr_valid`=1, `sum_err`=0 and `station_addr` holds the six address bytes. The two flags are never both high.
- R9: On a checksum mismatch, `sum_err`=1, `addr_valid`=0 and `station_addr`=0. Both flags clear on the cycle after a new read is accepted.
- R10: `done` is high for exactly one cycle, on the cycle where `busy` has just fallen. A `start` pulse while `busy` is high is ignored.
- R11: `ser_clk` is high only while `ser_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full image read (ignored while busy) |
| ser_cs | output | 1 | EEPROM chip select |
| ser_clk | output | 1 | EEPROM serial clock |
| ser_di | output | 1 | Data into the EEPROM |
| ser_do | input | 1 | Data out of the EEPROM |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| addr_valid | output | 1 | Checksum matched; address valid |
| sum_err | output | 1 | Checksum mismatch |
| station_addr | output | 48 | Six-byte station address, lowest-offset byte in the top bits |

## Verification
The hardest case to reach from the ports is a byte-order error that still leaves the checksum consistent. It arises when the image is swapped inside a word and all of its bytes happen to be equal. The bench therefore runs images whose bytes all differ and compares the full 48-bit address, not only the flag. A small EEPROM model decodes the pin waveform on every clock rise and answers with the selected word. Because the model checks the opcode and the sequential address itself, a restart caused by a `start` pulse issued mid-read shows up as an address out of order.

// File: rtl/mwr_pkg.sv
`timescale 1ns/1ps
package mwr_pkg;
  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } mw_pins_t;

  // One XOR step of the image checksum.
  function automatic logic [7:0] fold_byte(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction

  // Two bytes of a word: the first-read byte sits at the lower address.
  function automatic logic [15:0] word_to_mem(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/mwr_seq.sv
`timescale 1ns/1ps
module mwr_seq
  import mwr_pkg::*;
#(
  parameter int DELAY_CYC = 4,
  parameter int ADDR_BITS = 6,
  parameter int WORDS     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 ser_do,
  output mw_pins_t             pins,
  output logic                 busy,
  output logic                 step_adv,
  output logic                 word_we,
  output logic [ADDR_BITS-1:0] word_idx,
  output logic [15:0]          word_data,
  output logic                 last_done
);
  localparam int ADDR_FIRST = 9;
  localparam int ACK_STEP   = ADDR_FIRST + 2 * ADDR_BITS;
  localparam int DATA_FIRST = ACK_STEP + 1;
  localparam int END_STEP   = DATA_FIRST + 32;
  localparam int STEP_W     = $clog2(END_STEP + 1);
  localparam int CNT_W      = $clog2(DELAY_CYC + 1);
  localparam logic [STEP_W-1:0] S_ADDR = STEP_W'(ADDR_FIRST);
  localparam logic [STEP_W-1:0] S_ACK  = STEP_W'(ACK_STEP);
  localparam logic [STEP_W-1:0] S_DATA = STEP_W'(DATA_FIRST);
  localparam logic [STEP_W-1:0] S_LAST = STEP_W'(END_STEP - 1);
  localparam logic [STEP_W-1:0] S_END  = STEP_W'(END_STEP);
  localparam logic [CNT_W-1:0]  C_TOP  = CNT_W'(DELAY_CYC - 1);
  localparam logic [ADDR_BITS-1:0] W_LAST = ADDR_BITS'(WORDS - 1);
  // Preamble steps 1..8: clock high on even steps, data high on steps 3..6.
  localparam logic [15:0] PRE_SK = 16'b0000_0001_0101_0100;
  localparam logic [15:0] PRE_DI = 16'b0000_0000_0111_1000;

  logic [STEP_W-1:0]    step;
  logic [ADDR_BITS-1:0] word;
  logic [CNT_W-1:0]     dcnt;
  logic                 busy_q;
  logic [15:0]          shreg;
  logic [STEP_W-1:0]    dk;
  logic                 sample;

  function automatic mw_pins_t pins_for(input logic [STEP_W-1:0] s,
                                        input logic [ADDR_BITS-1:0] w);
    mw_pins_t p;
    int k;
    p = '0;
    k = 0;
    if (s == '0 || s == S_END) begin
      p = '0;
    end else if (s < S_ADDR) begin
      p.cs = 1'b1;
      p.sk = PRE_SK[s[3:0]];
      p.di = PRE_DI[s[3:0]];
    end else if (s < S_ACK) begin
      k = int'(s - S_ADDR);
      p.cs = 1'b1;
      p.sk = k[0];
      p.di = w[ADDR_BITS - 1 - (k / 2)];
    end else if (s == S_ACK) begin
      p.cs = 1'b1;
    end else begin
      k = int'(s - S_DATA);
      p.cs = 1'b1;
      p.sk = ~k[0];
    end
    return p;
  endfunction

  assign busy      = busy_q;
  assign step_adv  = busy_q && (dcnt == C_TOP);
  assign pins      = busy_q ? pins_for(step, word) : '0;
  assign dk        = step - S_DATA;
  assign sample    = step_adv && (step >= S_DATA) && (step < S_END) && dk[0];
  assign word_data = {shreg[14:0], ser_do};
  assign word_we   = sample && (step == S_LAST);
  assign word_idx  = word;
  assign last_done = step_adv && (step == S_END) && (word == W_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step   <= '0;
      word   <= '0;
      dcnt   <= '0;
      shreg  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        step   <= '0;
        word   <= '0;
        dcnt   <= '0;
      end
    end else begin
      if (sample) shreg <= {shreg[14:0], ser_do};
      if (step_adv) begin
        dcnt <= '0;
        if (step == S_END) begin
          step <= '0;
          if (word == W_LAST) busy_q <= 1'b0;
          else                word   <= word + 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mwr_image.sv
`timescale 1ns/1ps
module mwr_image
  import mwr_pkg::*;
#(
  parameter int IMG_BYTES = 32,
  parameter int ADDR_BITS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_BITS-1:0]   widx,
  input  logic [15:0]            wdata,
  output logic [IMG_BYTES*8-1:0] img
);
  localparam int WORDS = IMG_BYTES / 2;
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (!rst_n)                                 mem[i] <= '0;
      else if (we && widx == ADDR_BITS'(i))       mem[i] <= word_to_mem(wdata);
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign img[g*16 +: 16] = mem[g];
  end
endmodule

// File: rtl/mwr_verdict.sv
`timescale 1ns/1ps
module mwr_verdict
  import mwr_pkg::*;
#(
  parameter int IMG_BYTES = 32,
  parameter int KEY_OFS   = 0,
  parameter int SUM_OFS   = 15,
  parameter int MAC_OFS   = 16
) (
  input  logic [IMG_BYTES*8-1:0] img,
  output logic                   sum_ok,
  output logic [47:0]            mac
);
  logic [7:0] acc;

  always_comb begin
    acc = '0;
    for (int i = KEY_OFS; i < SUM_OFS; i++) acc = fold_byte(acc, img[i*8 +: 8]);
    sum_ok = (acc == img[SUM_OFS*8 +: 8]);
  end

  for (genvar j = 0; j < 6; j++) begin : g_mac
    assign mac[(5-j)*8 +: 8] = img[(MAC_OFS+j)*8 +: 8];
  end
endmodule

// File: rtl/mw_rom_loader.sv
`timescale 1ns/1ps
module mw_rom_loader
  import mwr_pkg::*;
#(
  parameter int DELAY_CYC = 4,
  parameter int ADDR_BITS = 6,
  parameter int IMG_BYTES = 32,
  parameter int KEY_OFS   = 0,
  parameter int SUM_OFS   = 15,
  parameter int MAC_OFS   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        ser_cs,
  output logic        ser_clk,
  output logic        ser_di,
  input  logic        ser_do,
  output logic        busy,
  output logic        done,
  output logic        addr_valid,
  output logic        sum_err,
  output logic [47:0] station_addr
);
  localparam int WORDS = IMG_BYTES / 2;

  mw_pins_t             pins;
  logic                 step_adv;
  logic                 word_we;
  logic [ADDR_BITS-1:0] word_idx;
  logic [15:0]          word_data;
  logic                 last_done;
  logic [IMG_BYTES*8-1:0] img;
  logic                 sum_ok;
  logic [47:0]          mac;
  logic                 start_ok;

  mwr_seq #(.DELAY_CYC(DELAY_CYC), .ADDR_BITS(ADDR_BITS), .WORDS(WORDS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ser_do(ser_do), .pins(pins),
    .busy(busy), .step_adv(step_adv), .word_we(word_we), .word_idx(word_idx),
    .word_data(word_data), .last_done(last_done)
  );

  mwr_image #(.IMG_BYTES(IMG_BYTES), .ADDR_BITS(ADDR_BITS)) img_i (
    .clk(clk), .rst_n(rst_n), .we(word_we), .widx(word_idx), .wdata(word_data), .img(img)
  );

  mwr_verdict #(.IMG_BYTES(IMG_BYTES), .KEY_OFS(KEY_OFS), .SUM_OFS(SUM_OFS),
                .MAC_OFS(MAC_OFS)) ver_i (
    .img(img), .sum_ok(sum_ok), .mac(mac)
  );

  assign ser_cs   = pins.cs;
  assign ser_clk  = pins.sk;
  assign ser_di   = pins.di;
  assign start_ok = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done         <= 1'b0;
      addr_valid   <= 1'b0;
      sum_err      <= 1'b0;
      station_addr <= '0;
    end else begin
      done <= last_done;
      if (start_ok) begin
        addr_valid   <= 1'b0;
        sum_err      <= 1'b0;
        station_addr <= '0;
      end else if (last_done) begin
        addr_valid   <= sum_ok;
        sum_err      <= !sum_ok;
        station_addr <= sum_ok ? mac : '0;
      end
    end
  end
endmodule

// File: rtl/mw_rom_loader_sva.sv
`timescale 1ns/1ps
module mw_rom_loader_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_cs,
  input logic        ser_clk,
  input logic        ser_di,
  input logic        busy,
  input logic        done,
  input logic        addr_valid,
  input logic        sum_err,
  input logic [47:0] station_addr,
  input logic        step_adv
);
  p_sk_needs_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> ser_cs);
  p_idle_pins_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_cs && !ser_clk && !ser_di));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && sum_err));
  p_err_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sum_err |-> (station_addr == 48'd0));
  p_pin_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step_adv) |-> $stable({ser_cs, ser_clk, ser_di}));
endmodule

bind mw_rom_loader mw_rom_loader_sva chk_i (
  .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_clk(ser_clk), .ser_di(ser_di),
  .busy(busy), .done(done), .addr_valid(addr_valid), .sum_err(sum_err),
  .station_addr(station_addr), .step_adv(step_adv)
);

// File: tb/mw_rom_loader_tb_top.sv
`timescale 1ns/1ps
module mw_rom_loader_tb_top;
  localparam int DLY = 4;
  localparam int PER = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ser_cs, ser_clk, ser_di, ser_do;
  logic busy, done, addr_valid, sum_err;
  logic [47:0] station_addr;

  always #(PER/2) clk = ~clk;

  mw_rom_loader #(.DELAY_CYC(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ser_cs(ser_cs), .ser_clk(ser_clk),
    .ser_di(ser_di), .ser_do(ser_do), .busy(busy), .done(done),
    .addr_valid(addr_valid), .sum_err(sum_err), .station_addr(station_addr)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // EEPROM model
  logic [7:0]  rom [32];
  bit          armed = 0;
  int          pulse = 0;
  logic [3:0]  hdr = '0;
  logic [5:0]  aacc = '0;
  logic [15:0] outw = '0;
  logic        do_r = 1'b0;
  int          exp_word = 0;
  assign ser_do = do_r;

  always @(posedge ser_cs) if (armed) begin
    pulse = 0;
    do_r  = 1'b0;
  end

  always @(negedge ser_cs) if (armed) chk(pulse == 26, "R5", 64'(pulse), 64'd26);

  always @(posedge ser_clk) if (armed) begin
    chk(ser_cs === 1'b1, "R11", 64'(ser_cs), 64'd1);
    pulse++;
    if (pulse <= 4)       hdr  = {hdr[2:0], ser_di};
    else if (pulse <= 10) aacc = {aacc[4:0], ser_di};
    if (pulse == 10) begin
      chk(hdr == 4'b0110, "R3", 64'(hdr), 64'h6);
      chk(aacc == exp_word[5:0], "R4", 64'(aacc), 64'(exp_word));
      outw = {rom[2*aacc], rom[2*aacc+1]};
      exp_word++;
    end
    if (pulse >= 11 && pulse <= 26) do_r = outw[26-pulse];
  end

  // pin hold-time monitor
  longint last_t = 0;
  bit     have_last = 0;
  always @(ser_cs or ser_clk or ser_di) if (armed && busy) begin
    if (have_last)
      chk((($time - last_t) % (DLY*PER)) == 0 && ($time - last_t) >= DLY*PER,
          "R6", 64'($time - last_t), 64'(DLY*PER));
    last_t = $time;
    have_last = 1;
  end

  // scoreboard
  typedef struct { bit ok; logic [47:0] mac; } exp_t;
  exp_t sbq[$];

  always @(negedge clk) if (armed && done) begin
    exp_t e;
    if (sbq.size() == 0) begin
      chk(0, "R10", 64'd1, 64'd0);
    end else begin
      e = sbq.pop_front();
      chk(addr_valid == e.ok, "R8", 64'(addr_valid), 64'(e.ok));
      chk(sum_err == !e.ok, "R9", 64'(sum_err), 64'(!e.ok));
      chk(station_addr == e.mac, "R7", 64'(station_addr), 64'(e.mac));
      chk(!busy, "R10", 64'(busy), 64'd0);
    end
  end

  task automatic run_image(input bit mid_start);
    exp_t e;
    logic [7:0] x;
    x = '0;
    for (int i = 0; i < 15; i++) x ^= rom[i];
    e.ok  = (x == rom[15]);
    e.mac = e.ok ? {rom[16], rom[17], rom[18], rom[19], rom[20], rom[21]} : 48'd0;
    sbq.push_back(e);
    exp_word  = 0;
    have_last = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!addr_valid && !sum_err, "R9", 64'({addr_valid, sum_err}), 64'd0);
    chk(busy, "R10", 64'(busy), 64'd1);
    if (mid_start) begin
      repeat (500) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
    chk(!done, "R10", 64'(done), 64'd0);
    chk({ser_cs, ser_clk, ser_di} == 3'b000, "R2", 64'({ser_cs, ser_clk, ser_di}), 64'd0);
    chk(exp_word == 16, "R4", 64'(exp_word), 64'd16);
    repeat (3) @(negedge clk);
  endtask

  task automatic fix_sum();
    logic [7:0] x;
    x = '0;
    for (int i = 0; i < 15; i++) x ^= rom[i];
    rom[15] = x;
  endtask

  initial begin
    repeat (PER * 0 + 150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({ser_cs, ser_clk, ser_di, busy, done} == 5'b0, "R1",
        64'({ser_cs, ser_clk, ser_di, busy, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1;
    chk({addr_valid, sum_err} == 2'b0 && station_addr == 48'd0, "R1",
        64'(station_addr), 64'd0);
    repeat (5) @(negedge clk);
    chk({ser_cs, ser_clk, ser_di} == 3'b000, "R2", 64'({ser_cs, ser_clk, ser_di}), 64'd0);

    // distinct bytes, good checksum, extra start mid-read
    for (int i = 0; i < 32; i++) rom[i] = 8'(i * 37 + 5);
    fix_sum();
    run_image(1'b1);

    // same image, corrupted checksum
    rom[15] = rom[15] ^ 8'h01;
    run_image(1'b0);

    // all zero: checksum 0 matches
    for (int i = 0; i < 32; i++) rom[i] = 8'h00;
    run_image(1'b0);

    // all ones: XOR of fifteen 0xFF is 0xFF
    for (int i = 0; i < 32; i++) rom[i] = 8'hFF;
    run_image(1'b0);

    // alternating key bytes, wrong checksum, nonzero address bytes
    for (int i = 0; i < 32; i++) rom[i] = (i % 2 == 0) ? 8'hA5 : 8'h3C;
    rom[15] = 8'h00;
    run_image(1'b0);

    // valid again after an error
    for (int i = 0; i < 32; i++) rom[i] = 8'(8'hF0 - i * 7);
    fix_sum();
    run_image(1'b0);

    chk(sbq.size() == 0, "R10", 64'(sbq.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule